// File: doc/BRIEF.md
# Signalling Channel Byte Accumulator

This block moves the low-rate signalling channel of a framed serial stream to and from a host, one byte at a time. In every frame it picks the signalling bit times out of the first timeslot. It shifts the incoming bits into a receive shifter and drives outgoing bits from a transmit shifter into the same bit times. Once eight bits have passed in each direction, it copies the finished receive byte into a holding register. It then loads the next host byte into the transmit shifter and raises an interrupt. The host can then read and write the single data register safely, even though its clock is asynchronous to the serial timing.

A rate select chooses 16 kb/s operation (two bits per frame, so a byte every 4 frames) or 8 kb/s operation (one bit per frame, so a byte every 8 frames). When the enable input is low, the block still collects received bits and keeps the holding register up to date. In that state the transmit slot output enable and the interrupt output enable are both held low. Host reads and writes cross into the serial clock domain as toggle events through a two-flop synchronizer.

Top module: `sigacc_top`

## Requirements
- R1: The signalling bits are the first bit times of channel 0. The bit time in which `frame_start` is high carries bit 7, and the following bit time carries bit 6. Bits go most significant first.
- R2: With `cfg_rate8` high, only the bit time marked by `frame_start` is used, so a byte is exchanged every 8 frames. With `cfg_rate8` low, two bits are used per frame, so a byte is exchanged every 4 frames.
- R3: After eight signalling bits have been received, a host read at address 8'h06 returns that byte. The first bit received lands in bit 7.
- R4: A byte written by the host at address 8'h06 is loaded at the next byte boundary. It is sent most significant bit first during the following byte period.
- R5: If no host write arrived before a byte boundary, the byte sent in the following period is 8'hFF.
- R6: `irq` goes high at each byte boundary and stays high until a host read at address 8'h06 clears it.
- R7: With `cfg_en` low, `sd_oe` and `irq_oe` stay low, but reception continues and the holding register still updates.
- R8: Host reads and writes at any address other than 8'h06 do not change the transmitted data and do not clear `irq`.
- R9: `sd_oe` is high only during signalling bit times while `cfg_en` is high.
- R10: After reset, `irq` is low, `h_rdata` is 8'h00, and the first byte sent is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock, one cycle per bit time |
| srst | input | 1 | Synchronous active-high reset, serial domain |
| frame_start | input | 1 | High during the first bit time of a frame |
| sdin | input | 1 | Serial receive data |
| cfg_en | input | 1 | Enables the transmit slot output and the interrupt output |
| cfg_rate8 | input | 1 | 1: one bit per frame, 0: two bits per frame |
| sd_out | output | 1 | Serial transmit data for the signalling bit times |
| sd_oe | output | 1 | Output enable for `sd_out` |
| irq | output | 1 | Byte-exchanged interrupt |
| irq_oe | output | 1 | Output enable for `irq` |
| hclk | input | 1 | Host clock |
| hrst | input | 1 | Synchronous active-high reset, host domain |
| h_sel | input | 1 | Host access strobe, one cycle |
| h_wr | input | 1 | 1: write, 0: read |
| h_addr | input | 8 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Registered host read data |

## Verification
The bench sweeps both rates over a series of bytes, with the enable input dropped for one byte period. A design that took the wrong bit time, or the wrong count of bits per frame, returns shifted or mixed bytes and moves its boundary, so the interrupt rises in the wrong frame. It follows each written byte through one full boundary and then an unwritten one. This catches a design that resends stale data instead of all ones, or that loads the write one period early. It also makes reads and writes at a neighbouring address. A design with loose address decoding would then clear the interrupt or change the outgoing byte. Received bytes are read back while the block is disabled, which shows that reception was not wrongly gated.

// File: rtl/sigacc_pkg.sv
package sigacc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t IDLE_FILL = '1;
    localparam logic [7:0] DATA_ADDR = 8'h06;

    typedef struct packed {
        byte_t            rx_sh;
        byte_t            tx_sh;
        byte_t            hold;
        byte_t            pend;
        logic             pend_v;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } acc_state_t;

    function automatic byte_t next_tx(input logic valid, input byte_t data);
        return valid ? data : IDLE_FILL;
    endfunction

    function automatic byte_t shift_in(input byte_t cur, input logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction
endpackage

// File: rtl/sigacc_slot_timer.sv
module sigacc_slot_timer #(
    parameter int FRAME_BITS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic rate8,
    output logic slot_hit
);
    localparam int PW = $clog2(FRAME_BITS + 1);
    localparam logic [PW-1:0] POS_MAX = PW'(FRAME_BITS);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] cur;

    always_comb begin
        cur      = frame_start ? '0 : pos_q;
        slot_hit = frame_start || (!rate8 && (cur == PW'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= POS_MAX;
        end else if (cur == POS_MAX) begin
            pos_q <= cur;
        end else begin
            pos_q <= cur + PW'(1);
        end
    end
endmodule

// File: rtl/sigacc_evt_sync.sv
module sigacc_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic evt
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], tgl_in};
        end
    end

    assign evt = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/sigacc_host_if.sv
module sigacc_host_if
    import sigacc_pkg::*;
(
    input  logic       hclk,
    input  logic       hrst,
    input  logic       h_sel,
    input  logic       h_wr,
    input  logic [7:0] h_addr,
    input  byte_t      h_wdata,
    input  byte_t      rx_hold,
    output byte_t      h_rdata,
    output byte_t      wbuf,
    output logic       wr_tgl,
    output logic       rd_tgl
);
    logic hit;
    assign hit = h_sel && (h_addr == DATA_ADDR);

    always_ff @(posedge hclk) begin
        if (hrst) begin
            h_rdata <= '0;
            wbuf    <= IDLE_FILL;
            wr_tgl  <= 1'b0;
            rd_tgl  <= 1'b0;
        end else if (hit) begin
            if (h_wr) begin
                wbuf   <= h_wdata;
                wr_tgl <= ~wr_tgl;
            end else begin
                h_rdata <= rx_hold;
                rd_tgl  <= ~rd_tgl;
            end
        end
    end
endmodule

// File: rtl/sigacc_shift.sv
module sigacc_shift
    import sigacc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_hit,
    input  logic  sdin,
    input  logic  wr_evt,
    input  byte_t wbuf,
    input  logic  rd_evt,
    output logic  tx_bit,
    output byte_t rx_hold,
    output logic  irq_flag
);
    acc_state_t st_q, st_d;
    logic       boundary;

    always_comb begin
        st_d     = st_q;
        boundary = slot_hit && (st_q.cnt == CNT_W'(BYTE_W - 1));
        if (rd_evt) begin
            st_d.irq = 1'b0;
        end
        if (slot_hit) begin
            st_d.rx_sh = shift_in(st_q.rx_sh, sdin);
            st_d.tx_sh = shift_in(st_q.tx_sh, 1'b1);
            st_d.cnt   = st_q.cnt + CNT_W'(1);
        end
        if (boundary) begin
            st_d.hold   = shift_in(st_q.rx_sh, sdin);
            st_d.tx_sh  = next_tx(st_q.pend_v, st_q.pend);
            st_d.pend_v = 1'b0;
            st_d.irq    = 1'b1;
        end
        if (wr_evt) begin
            st_d.pend   = wbuf;
            st_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rx_sh  <= '0;
            st_q.tx_sh  <= IDLE_FILL;
            st_q.hold   <= '0;
            st_q.pend   <= IDLE_FILL;
            st_q.pend_v <= 1'b0;
            st_q.cnt    <= '0;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_bit   = st_q.tx_sh[BYTE_W-1];
    assign rx_hold  = st_q.hold;
    assign irq_flag = st_q.irq;
endmodule

// File: rtl/sigacc_top.sv
module sigacc_top
    import sigacc_pkg::*;
#(
    parameter int FRAME_BITS  = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       sclk,
    input  logic       srst,
    input  logic       frame_start,
    input  logic       sdin,
    input  logic       cfg_en,
    input  logic       cfg_rate8,
    output logic       sd_out,
    output logic       sd_oe,
    output logic       irq,
    output logic       irq_oe,
    input  logic       hclk,
    input  logic       hrst,
    input  logic       h_sel,
    input  logic       h_wr,
    input  logic [7:0] h_addr,
    input  logic [7:0] h_wdata,
    output logic [7:0] h_rdata
);
    logic  slot_hit;
    logic  wr_tgl, rd_tgl, wr_evt, rd_evt;
    byte_t wbuf, rx_hold;
    logic  tx_bit, irq_flag;

    sigacc_slot_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
        .clk(sclk), .rst(srst), .frame_start(frame_start),
        .rate8(cfg_rate8), .slot_hit(slot_hit)
    );

    sigacc_host_if u_host (
        .hclk(hclk), .hrst(hrst), .h_sel(h_sel), .h_wr(h_wr),
        .h_addr(h_addr), .h_wdata(h_wdata), .rx_hold(rx_hold),
        .h_rdata(h_rdata), .wbuf(wbuf), .wr_tgl(wr_tgl), .rd_tgl(rd_tgl)
    );

    sigacc_evt_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(sclk), .rst(srst), .tgl_in(wr_tgl), .evt(wr_evt)
    );

    sigacc_evt_sync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk(sclk), .rst(srst), .tgl_in(rd_tgl), .evt(rd_evt)
    );

    sigacc_shift u_shift (
        .clk(sclk), .rst(srst), .slot_hit(slot_hit), .sdin(sdin),
        .wr_evt(wr_evt), .wbuf(wbuf), .rd_evt(rd_evt),
        .tx_bit(tx_bit), .rx_hold(rx_hold), .irq_flag(irq_flag)
    );

    assign sd_out = tx_bit;
    assign sd_oe  = slot_hit && cfg_en;
    assign irq    = irq_flag;
    assign irq_oe = cfg_en;
endmodule

// File: rtl/sigacc_checker.sv
module sigacc_checker
    import sigacc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  cfg_en,
    input logic  cfg_rate8,
    input logic  frame_start,
    input logic  sd_oe,
    input logic  irq_oe,
    input logic  slot_hit,
    input logic  irq,
    input byte_t rx_hold
);
    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> (!sd_oe && !irq_oe));

    // R2
    single_bit_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rate8 && sd_oe) |-> frame_start);

    // R1
    second_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_hit && !frame_start) |-> ($past(frame_start) && !cfg_rate8));

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(slot_hit));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(slot_hit) |-> $stable(rx_hold));
endmodule

bind sigacc_top sigacc_checker u_chk (
    .clk(sclk), .rst(srst), .cfg_en(cfg_en), .cfg_rate8(cfg_rate8),
    .frame_start(frame_start), .sd_oe(sd_oe), .irq_oe(irq_oe),
    .slot_hit(slot_hit), .irq(irq), .rx_hold(rx_hold)
);

// File: tb/sim_sigacc_top.sv
`timescale 1ns/1ps
module sim_sigacc_top;
    localparam int FB = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0, sdin = 1'b0, cfg_en = 1'b1, cfg_rate8 = 1'b0;
    logic       sd_out, sd_oe, irq, irq_oe;
    logic       h_sel = 1'b0, h_wr = 1'b0;
    logic [7:0] h_addr = 8'h00, h_wdata = 8'h00, h_rdata;

    int n_chk = 0, n_bad = 0;
    logic [7:0] tb_cur = 8'hFF, tb_pend = 8'h00;
    logic       tb_pv = 1'b0;

    always #4 clk = ~clk;

    sigacc_top #(.FRAME_BITS(FB)) u0 (
        .sclk(clk), .srst(rst), .frame_start(frame_start), .sdin(sdin),
        .cfg_en(cfg_en), .cfg_rate8(cfg_rate8), .sd_out(sd_out), .sd_oe(sd_oe),
        .irq(irq), .irq_oe(irq_oe), .hclk(clk), .hrst(rst), .h_sel(h_sel),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic host(input logic wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        h_sel = 1'b1; h_wr = wr; h_addr = a; h_wdata = d;
        @(negedge clk);
        h_sel = 1'b0; h_wr = 1'b0;
        idle(5);
    endtask

    task automatic run_byte(input logic [7:0] rxb, input logic r8, input logic en);
        int nb, k;
        nb = r8 ? 1 : 2;
        k = 0;
        cfg_rate8 = r8;
        cfg_en = en;
        for (int f = 0; f < 8 / nb; f++) begin
            for (int i = 0; i < FB; i++) begin
                @(negedge clk);
                frame_start = (i == 0);
                sdin = (i < nb) ? rxb[7-k] : i[0];
                #1;
                // R9 R1 R2: output enable only in the chosen bit times
                chk("R9", {7'd0, sd_oe}, {7'd0, (i < nb) && en});
                if (i < nb && en) chk("R4/R5 bit", {7'd0, sd_out}, {7'd0, tb_cur[7-k]});
                if (i < nb) k++;
            end
        end
        @(negedge clk);
        frame_start = 1'b0;
        tb_cur = tb_pv ? tb_pend : 8'hFF;
        tb_pv = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rxb, wd;
        logic en;
        idle(4);
        rst = 1'b0;
        idle(2);
        // R10 reset state
        chk("R10 irq", {7'd0, irq}, 8'd0);
        chk("R10 rdata", h_rdata, 8'h00);
        chk("R10 sd_oe", {7'd0, sd_oe}, 8'd0);
        for (int r = 0; r < 2; r++) begin
            for (int j = 0; j < 6; j++) begin
                en  = (j != 3);
                rxb = 8'hC3 + 8'(j * 29) + 8'(r * 7);
                wd  = 8'h5A ^ 8'(j * 37) ^ 8'(r);
                if (j % 2 == 0) begin
                    host(1'b1, 8'h06, wd);
                    tb_pend = wd; tb_pv = 1'b1;
                end
                if (j == 1) host(1'b1, 8'h07, 8'h00);   // R8 ignored write
                run_byte(rxb, r[0], en);
                // R7 gating of interrupt pin
                chk("R7 irq_oe", {7'd0, irq_oe}, {7'd0, en});
                if (en) chk("R6 irq set", {7'd0, irq}, 8'd1);
                if (j == 2) begin
                    host(1'b0, 8'h07, 8'h00);
                    chk("R8 irq kept", {7'd0, irq}, 8'd1);
                end
                host(1'b0, 8'h06, 8'h00);
                // R3 received byte (R7 when disabled)
                chk(en ? "R3 rx" : "R7 rx", h_rdata, rxb);
                if (en) chk("R6 irq clr", {7'd0, irq}, 8'd0);
            end
        end
        cfg_en = 1'b1;
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule